// File: doc/BRIEF.md
# Programmed-IO Sample Byte Sequencer

This block sits between an 8-bit host register port and multi-byte audio samples that the converter FIFOs move whole. On the capture side it holds one sample taken from the ADC FIFO and hands it out one byte per host read of the data port. A pointer tracks which byte the next read returns. On the playback side it collects host byte writes into one sample and passes the finished sample to the DAC FIFO. Both FIFOs are modelled as valid/ready handshakes.

A strobe that marks a host read of the status register tells both sequencers to move to the next sample. The current byte positions are exported so that the status register can report them. A format input sets the number of bytes per sample. While the codec is initializing or powered down, the data port is inert and reads a fixed mid-scale value.

Top module: `pio_sample_seq`

## Requirements
- R1: When a host read (`hostRd`) occurs with `powerDown` low, no ADC handshake in that cycle, and `capIdx` below the last byte index, `capIdx` increases by one. The next read therefore returns the next byte of the same sample.
- R2: `hostRdData` equals byte `capIdx` of the held capture sample, where byte k is bits [8k+7:8k]. `capIdx` reads 0 right after a sample is loaded.
- R3: Once `capIdx` reaches the last byte index (bytes per sample minus one), further reads leave it there and keep returning the last byte.
- R4: A new capture sample is accepted, and `capIdx` goes back to 0, only when both of these hold: a status read has happened since the previous sample was loaded, and the ADC FIFO offers a sample (`adcValid`). A sample offered before that status read is not taken.
- R5: While `powerDown` is high, `hostRdData` is 8'h80. Host reads do not move `capIdx`, and host writes do not move `playIdx`.
- R6: A host write (`hostWr`) stores `hostWrData` in byte `playIdx` of the playback sample and increments `playIdx`. Bytes are ordered little-endian, with the left channel before the right.
- R7: When `playIdx` equals the bytes-per-sample count, further host writes are discarded and leave `playIdx` and the sample unchanged.
- R8: A status read while the playback sample is complete raises `dacValid`, with `dacData` holding the assembled sample. When `dacValid` and `dacReady` are both high, `dacValid` drops, `playIdx` returns to 0 and the assembled sample is cleared to zero.
- R9: While `dacValid` is high and `dacReady` is low, `dacValid` and `dacData` hold their values and host writes are blocked.
- R10: `fmt` sets the bytes per sample: 0 gives 1 byte (8-bit mono), 1 gives 2 bytes (16-bit mono or 8-bit stereo), and 2 or 3 give 4 bytes (16-bit stereo). Bytes of the playback sample that are never written read as zero.
- R11: A status read while the playback sample is incomplete discards the partial sample and returns `playIdx` to 0, and nothing is pushed to the DAC FIFO. The status read takes priority over a host write in the same cycle.
- R12: `adcReady` is high out of reset. A status read sets it on the next cycle, and it stays high until an ADC sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerDown | input | 1 | Codec initializing or powered down; data port inert |
| fmt | input | 2 | Sample format (bytes per sample) |
| hostRd | input | 1 | Host read strobe of the capture data port |
| hostWr | input | 1 | Host write strobe of the playback data port |
| hostWrData | input | BYTE_W | Host write byte |
| statusRd | input | 1 | Host read strobe of the status register |
| hostRdData | output | BYTE_W | Capture byte presented to the host |
| capIdx | output | IDX_W | Index of the next capture byte |
| playIdx | output | CNT_W | Number of playback bytes written so far |
| adcValid | input | 1 | ADC FIFO offers a sample |
| adcData | input | SAMPLE_W | ADC FIFO sample |
| adcReady | output | 1 | Sequencer will accept an ADC sample |
| dacValid | output | 1 | Assembled playback sample offered |
| dacData | output | SAMPLE_W | Assembled playback sample |
| dacReady | input | 1 | DAC FIFO accepts the sample |

## Verification
The bench builds the block with its defaults: 8-bit bytes and room for four bytes per sample. With these values every format can be reached, from the single-byte case, where the pointer is saturated from the start, to the four-byte case, where the pointer runs the full index range. Random sample words and random formats show that each byte lane is stored and presented at the correct position. Directed steps offer ADC samples before any status read, hold the DAC handshake off, and issue a status read on a partial sample, so that the rules for moving to the next sample are exercised in both directions.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capLoad;  // take a new ADC sample into the capture register
    logic playWr;   // store the host byte at the playback pointer
    logic playClr;  // clear the playback assembly register
  } seqStrobe_t;

  // Bytes per sample for each format code
  function automatic int unsigned fmtBytes(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/pio_seq_ctrl.sv
module pio_seq_ctrl
  import pio_seq_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerDown,
  input  logic [1:0]       fmt,
  input  logic             hostRd,
  input  logic             hostWr,
  input  logic             statusRd,
  input  logic             adcValid,
  output logic             adcReady,
  output logic             dacValid,
  input  logic             dacReady,
  output logic [IDX_W-1:0] capIdx,
  output logic [CNT_W-1:0] playCnt,
  output seqStrobe_t       strb
);

  logic [CNT_W-1:0] nBytes;
  logic [IDX_W-1:0] lastIdx;
  logic             capPending;
  logic             dacValidQ;
  logic             adcAccept;
  logic             dacAccept;
  logic             playFull;

  always_comb begin
    if (fmtBytes(fmt) > MAX_BYTES) nBytes = CNT_W'(MAX_BYTES);
    else                           nBytes = CNT_W'(fmtBytes(fmt));
    lastIdx   = IDX_W'(nBytes - 1'b1);
    adcAccept = adcValid & capPending;
    dacAccept = dacValidQ & dacReady;
    playFull  = (playCnt == nBytes);

    strb.capLoad = adcAccept;
    strb.playClr = dacAccept | (statusRd & ~playFull);
    strb.playWr  = hostWr & ~powerDown & ~playFull & ~dacValidQ & ~statusRd;
  end

  // Capture side: pointer and pending restart flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capPending <= 1'b1;
      capIdx     <= '0;
    end else begin
      capPending <= statusRd | (capPending & ~adcAccept);
      if (adcAccept)
        capIdx <= '0;
      else if (hostRd && !powerDown && (capIdx < lastIdx))
        capIdx <= capIdx + 1'b1;
    end
  end

  // Playback side: byte count and DAC offer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      playCnt   <= '0;
      dacValidQ <= 1'b0;
    end else begin
      if (dacAccept)
        dacValidQ <= 1'b0;
      else if (statusRd && playFull)
        dacValidQ <= 1'b1;

      if (strb.playClr)
        playCnt <= '0;
      else if (strb.playWr)
        playCnt <= playCnt + 1'b1;
    end
  end

  assign adcReady = capPending;
  assign dacValid = dacValidQ;

endmodule

// File: rtl/pio_seq_datapath.sv
module pio_seq_datapath
  import pio_seq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        powerDown,
  input  seqStrobe_t                  strb,
  input  logic [BYTE_W*MAX_BYTES-1:0] adcData,
  input  logic [BYTE_W-1:0]           hostWrData,
  input  logic [IDX_W-1:0]            capIdx,
  input  logic [IDX_W-1:0]            playWrIdx,
  output logic [BYTE_W-1:0]           hostRdData,
  output logic [BYTE_W*MAX_BYTES-1:0] dacData
);

  localparam int SAMPLE_W = BYTE_W * MAX_BYTES;
  localparam logic [BYTE_W-1:0] QUIET_BYTE = BYTE_W'(1) << (BYTE_W - 1);

  logic [SAMPLE_W-1:0] capReg;
  logic [SAMPLE_W-1:0] playReg;

  always_ff @(posedge clk) begin
    if (!rstN)             capReg <= '0;
    else if (strb.capLoad) capReg <= adcData;
  end

  // One assembly lane per byte position
  for (genvar g = 0; g < MAX_BYTES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN || strb.playClr)
        playReg[g*BYTE_W +: BYTE_W] <= '0;
      else if (strb.playWr && (int'(playWrIdx) == g))
        playReg[g*BYTE_W +: BYTE_W] <= hostWrData;
    end
  end

  always_comb begin
    if (powerDown) hostRdData = QUIET_BYTE;
    else           hostRdData = capReg[int'(capIdx)*BYTE_W +: BYTE_W];
  end

  assign dacData = playReg;

endmodule

// File: rtl/pio_sample_seq.sv
module pio_sample_seq
  import pio_seq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int SAMPLE_W = BYTE_W * MAX_BYTES,
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                powerDown,
  input  logic [1:0]          fmt,
  input  logic                hostRd,
  input  logic                hostWr,
  input  logic [BYTE_W-1:0]   hostWrData,
  input  logic                statusRd,
  output logic [BYTE_W-1:0]   hostRdData,
  output logic [IDX_W-1:0]    capIdx,
  output logic [CNT_W-1:0]    playIdx,
  input  logic                adcValid,
  input  logic [SAMPLE_W-1:0] adcData,
  output logic                adcReady,
  output logic                dacValid,
  output logic [SAMPLE_W-1:0] dacData,
  input  logic                dacReady
);

  seqStrobe_t strb;

  pio_seq_ctrl #(
    .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .fmt(fmt),
    .hostRd(hostRd), .hostWr(hostWr), .statusRd(statusRd),
    .adcValid(adcValid), .adcReady(adcReady),
    .dacValid(dacValid), .dacReady(dacReady),
    .capIdx(capIdx), .playCnt(playIdx), .strb(strb)
  );

  pio_seq_datapath #(
    .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .strb(strb),
    .adcData(adcData), .hostWrData(hostWrData),
    .capIdx(capIdx), .playWrIdx(playIdx[IDX_W-1:0]),
    .hostRdData(hostRdData), .dacData(dacData)
  );

endmodule

// File: rtl/pio_sample_seq_chk.sv
module pio_sample_seq_chk
  import pio_seq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        powerDown,
  input logic [1:0]                  fmt,
  input logic                        hostRd,
  input logic                        hostWr,
  input logic                        statusRd,
  input logic [BYTE_W-1:0]           hostRdData,
  input logic [IDX_W-1:0]            capIdx,
  input logic [CNT_W-1:0]            playIdx,
  input logic                        adcValid,
  input logic                        adcReady,
  input logic                        dacValid,
  input logic [BYTE_W*MAX_BYTES-1:0] dacData,
  input logic                        dacReady
);

  logic [CNT_W-1:0] nB;
  logic [IDX_W-1:0] lastB;
  logic             adcTake;
  always_comb begin
    if (fmtBytes(fmt) > MAX_BYTES) nB = CNT_W'(MAX_BYTES);
    else                           nB = CNT_W'(fmtBytes(fmt));
    lastB   = IDX_W'(nB - 1'b1);
    adcTake = adcValid & adcReady;
  end

  AST_CAP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !powerDown && !adcTake && capIdx < lastB) |=> capIdx == $past(capIdx) + 1'b1); // R1

  AST_CAP_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !adcTake && capIdx == lastB && $stable(fmt)) |=> capIdx == $past(capIdx)); // R3

  AST_CAP_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    adcTake |=> capIdx == '0); // R4

  AST_READY_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcReady) |-> $past(statusRd)); // R12

  AST_QUIET_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> hostRdData == 8'h80); // R5

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && !adcTake) |=> capIdx == $past(capIdx)); // R5

  AST_PLAY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    playIdx <= CNT_W'(MAX_BYTES)); // R7

  AST_DAC_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (dacValid && $stable(fmt)) |-> playIdx == nB); // R8

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dacValid && !dacReady) |=> dacValid && $stable(dacData) && $stable(playIdx)); // R9

endmodule

bind pio_sample_seq pio_sample_seq_chk #(
  .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .powerDown(powerDown), .fmt(fmt),
  .hostRd(hostRd), .hostWr(hostWr), .statusRd(statusRd),
  .hostRdData(hostRdData), .capIdx(capIdx), .playIdx(playIdx),
  .adcValid(adcValid), .adcReady(adcReady),
  .dacValid(dacValid), .dacData(dacData), .dacReady(dacReady)
);

// File: tb/pio_sample_seq_tb.sv
module pio_sample_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        powerDown;
  logic [1:0]  fmt;
  logic        hostRd, hostWr, statusRd;
  logic [7:0]  hostWrData;
  logic [7:0]  hostRdData;
  logic [1:0]  capIdx;
  logic [2:0]  playIdx;
  logic        adcValid, adcReady;
  logic [31:0] adcData;
  logic        dacValid, dacReady;
  logic [31:0] dacData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pio_sample_seq dut_i (
    .clk(clk), .rstN(rstN), .powerDown(powerDown), .fmt(fmt),
    .hostRd(hostRd), .hostWr(hostWr), .hostWrData(hostWrData),
    .statusRd(statusRd), .hostRdData(hostRdData), .capIdx(capIdx),
    .playIdx(playIdx), .adcValid(adcValid), .adcData(adcData),
    .adcReady(adcReady), .dacValid(dacValid), .dacData(dacData),
    .dacReady(dacReady)
  );

  function automatic int nOf(input logic [1:0] f);
    return (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] byteOf(input logic [31:0] s, input int k);
    return s[k*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic statusPulse();
    @(negedge clk); statusRd = 1'b1;
    @(negedge clk); statusRd = 1'b0;
  endtask

  task automatic deliver(input logic [31:0] s);
    @(negedge clk);
    chk(adcReady == 1'b1, "R12 ready before load", adcReady, 1);
    adcValid = 1'b1; adcData = s;
    @(negedge clk); adcValid = 1'b0;
    chk(capIdx == 2'd0, "R2 index after load", capIdx, 0);
    chk(adcReady == 1'b0, "R12 ready drops after load", adcReady, 0);
  endtask

  // Read one byte; check presented byte and index before the strobe edge
  task automatic readByte(input logic [31:0] s, input int expIdx, input string req);
    @(negedge clk); hostRd = 1'b1;
    #1;
    chk(capIdx == 2'(expIdx), req, capIdx, expIdx);
    chk(hostRdData == byteOf(s, expIdx), req, hostRdData, byteOf(s, expIdx));
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk); hostWr = 1'b1; hostWrData = b;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic captureRound(input logic [1:0] f, input logic [31:0] s);
    int n;
    n = nOf(f);
    fmt = f;
    deliver(s);
    for (int i = 0; i < n + 2; i++)
      readByte(s, (i < n) ? i : n - 1, (i < n) ? "R1 capture sequence" : "R3 saturated read");
    // sample offered before any status read must be refused
    @(negedge clk); adcValid = 1'b1; adcData = ~s;
    #1 chk(adcReady == 1'b0, "R4 no restart without status read", adcReady, 0);
    @(negedge clk); @(negedge clk); adcValid = 1'b0;
    readByte(s, n - 1, "R4 old sample kept");
    statusPulse();
    chk(adcReady == 1'b1, "R12 ready after status read", adcReady, 1);
    chk(capIdx == 2'(n - 1), "R4 index kept until new sample", capIdx, n - 1);
  endtask

  task automatic playbackRound(input logic [1:0] f, input int holdCycles);
    int n;
    logic [31:0] exp;
    n = nOf(f);
    fmt = f;
    exp = '0;
    for (int i = 0; i < n + 2; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (i < n) exp[i*8 +: 8] = b;
      writeByte(b);
      chk(playIdx == 3'((i < n) ? i + 1 : n), (i < n) ? "R6 write advance" : "R7 surplus write ignored",
          playIdx, (i < n) ? i + 1 : n);
    end
    chk(dacValid == 1'b0, "R8 no offer before status read", dacValid, 0);
    statusPulse();
    chk(dacValid == 1'b1, "R8 offer after status read", dacValid, 1);
    chk(dacData == exp, "R10 assembled sample", dacData, exp);
    for (int h = 0; h < holdCycles; h++) begin
      writeByte(8'hA5);
      chk(dacValid == 1'b1 && dacData == exp, "R9 hold while not ready", dacData, exp);
      chk(playIdx == 3'(n), "R9 write blocked", playIdx, n);
    end
    @(negedge clk); dacReady = 1'b1;
    @(negedge clk); dacReady = 1'b0;
    chk(dacValid == 1'b0, "R8 offer dropped after accept", dacValid, 0);
    chk(playIdx == 3'd0, "R8 index restarted", playIdx, 0);
    chk(dacData == 32'd0, "R8 sample cleared", dacData, 0);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; powerDown = 1'b0; fmt = 2'd0;
    hostRd = 1'b0; hostWr = 1'b0; hostWrData = '0; statusRd = 1'b0;
    adcValid = 1'b0; adcData = '0; dacReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(capIdx == 2'd0 && playIdx == 3'd0, "R2 reset indices", {capIdx, playIdx}, 0);
    chk(adcReady == 1'b1, "R12 ready out of reset", adcReady, 1);
    chk(dacValid == 1'b0, "R8 no offer out of reset", dacValid, 0);

    // Directed: each format once, known pattern
    captureRound(2'd0, 32'h44332211);
    captureRound(2'd1, 32'h44332211);
    captureRound(2'd2, 32'h44332211);
    captureRound(2'd3, 32'hDDCCBBAA);

    // Power-down: port inert
    deliver(32'h5A6B7C8D);
    fmt = 2'd2;
    readByte(32'h5A6B7C8D, 0, "R1 read before power-down");
    @(negedge clk); powerDown = 1'b1;
    #1 chk(hostRdData == 8'h80, "R5 quiet byte", hostRdData, 8'h80);
    hostRd = 1'b1; hostWr = 1'b1; hostWrData = 8'hEE;
    @(negedge clk); @(negedge clk); hostRd = 1'b0; hostWr = 1'b0;
    chk(capIdx == 2'd1, "R5 read ignored", capIdx, 1);
    chk(playIdx == 3'd0, "R5 write ignored", playIdx, 0);
    @(negedge clk); powerDown = 1'b0;
    readByte(32'h5A6B7C8D, 1, "R5 resume after power-down");
    statusPulse();

    // Partial playback sample discarded
    fmt = 2'd2;
    writeByte(8'h11); writeByte(8'h22);
    chk(playIdx == 3'd2, "R6 partial count", playIdx, 2);
    statusPulse();
    chk(playIdx == 3'd0, "R11 partial discarded", playIdx, 0);
    chk(dacValid == 1'b0, "R11 nothing pushed", dacValid, 0);
    // status read wins over simultaneous write
    @(negedge clk); statusRd = 1'b1; hostWr = 1'b1; hostWrData = 8'h77;
    @(negedge clk); statusRd = 1'b0; hostWr = 1'b0;
    chk(playIdx == 3'd0, "R11 status read has priority", playIdx, 0);

    // Directed playback per format
    playbackRound(2'd0, 0);
    playbackRound(2'd1, 2);
    playbackRound(2'd2, 3);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] f;
      f = 2'($urandom);
      if ($urandom % 2 == 0) captureRound(f, $urandom);
      else                   playbackRound(f, int'($urandom % 4));
    end

    finishRun();
  end

endmodule